// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block sits between a host register bus and a downstream request/response port. Software never addresses a downstream device directly. It first loads a 32-bit target address into a latch register. It then reads or writes one of two four-byte data windows. An access to the configuration window starts one configuration cycle, and an access to the port window starts one I/O port cycle. The host's transfer size and the low offset bits of the window access set the byte enables of that downstream cycle.

The host side uses a request/acknowledge handshake. The host raises `host_req` with its command fields and holds them until it sees `host_ack`, which is a one-cycle pulse. The host drops or replaces the request in the cycle where `host_ack` is high. An access to a data window holds off the acknowledge until the downstream port answers, so only one transaction is ever in flight. A three-state sequencer controls the block. The states are ST_IDLE (waiting for a host request), ST_DOWN (a downstream request is active) and ST_DONE (the one-cycle host acknowledge). The transitions are:
- ST_IDLE to ST_DOWN on a window access.
- ST_IDLE to ST_DONE on any other access.
- ST_DOWN to ST_DONE on `dn_ack`.
- ST_DONE to ST_IDLE unconditionally.

Top module: `cfgio_window`

## Requirements
- R1: Offset 0x064 is the target address latch. A write stores all 32 bits of `host_wdata`, whatever the size. A read returns the stored value. An access to this latch never raises `dn_req`.
- R2: A read of the configuration window (offset 0x068 to 0x06B) issues one downstream cycle with `dn_kind`=0 and `dn_we`=0. A write issues the same cycle with `dn_we`=1.
- R3: A read or write of the port window (offset 0x06C to 0x06F) issues one downstream cycle with `dn_kind`=1, and `dn_we` follows the host direction.
- R4: A configuration cycle carries the latch with bits 1:0 forced to zero. In that value, bits 23:16 hold the bus, bits 15:8 hold device/function and bits 7:0 hold the register offset.
- R5: A port cycle carries the latch value unchanged as the port address.
- R6: `dn_be` is set by `host_size` and `host_addr[1:0]`. Size 0 (byte) gives `1<<host_addr[1:0]`. Size 1 (halfword) gives 4'b1100 when `host_addr[1]` is set and 4'b0011 otherwise. Sizes 2 and 3 give 4'b1111.
- R7: On a write cycle, `dn_wdata` holds `host_wdata` on the enabled byte lanes and zero on every other lane.
- R8: A window read returns `dn_rdata` in its lane positions, with lanes that were not enabled reading as zero.
- R9: `host_ack` is a one-cycle pulse. For a window access it comes only after `dn_ack`. `dn_req` and all downstream fields hold steady until `dn_ack`, and each window access makes exactly one downstream cycle.
- R10: After `dn_ack`, `dn_req` stays low for at least one cycle, also when the next cycle changes type. A window access that immediately follows a latch write uses the new latch value.
- R11: Any other offset is acknowledged without a downstream cycle. A read there returns zero, and a write there changes nothing.
- R12: After reset, `dn_req` and `host_ack` are low and the latch holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte offset |
| host_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Host write data, lane-positioned |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 32 | Read data, valid with host_ack |
| dn_req | output | 1 | Downstream request |
| dn_kind | output | 1 | 0 configuration cycle, 1 port cycle |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, sampled with dn_ack |

## Verification
Two functions can meet at the same clock edge. A latch write can complete right when the following window access is captured, and the end of one downstream cycle can collide with the launch of the next. Both are provoked by keeping `host_req` high across acknowledges, so that a latch write is followed at once by a configuration access and a configuration access by a port access. A randomized responder latency moves the collision point around. The bench judges the first case by comparing the captured `dn_addr` with the newly written latch value. It judges the second by watching that `dn_req` is low on the cycle after every `dn_ack`.

// File: rtl/cfgio_window_pkg.sv
package cfgio_window_pkg;

    typedef enum logic {
        KIND_CFG = 1'b0,
        KIND_IO  = 1'b1
    } cyc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ADDR = 2'd1,
        TGT_CFG  = 2'd2,
        TGT_IO   = 2'd3
    } win_tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DOWN = 2'd1,
        ST_DONE = 2'd2
    } fsm_state_e;

endpackage

// File: rtl/cfgio_lane_gen.sv
// Turns the host sub-word offset and transfer size into lane enables
// and the matching bit mask.
module cfgio_lane_gen
    import cfgio_window_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES = DW / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lane_en,
    output logic [DW-1:0]    bit_mask
);

    localparam logic [LANES-1:0] ONE_LANE  = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANES = LANES'(3);

    logic [OFS_W-1:0] half_base;

    always_comb begin
        half_base    = offset;
        half_base[0] = 1'b0;
        case (xfer_size_e'(size))
            SZ_BYTE: lane_en = ONE_LANE << offset;
            SZ_HALF: lane_en = TWO_LANES << half_base;
            default: lane_en = '1;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_mask[g*8 +: 8] = {8{lane_en[g]}};
    end

endmodule

// File: rtl/cfgio_decode.sv
// Classifies the dword index of a host access.
module cfgio_decode
    import cfgio_window_pkg::*;
#(
    parameter int AW = 12,
    parameter int OFS_W = 2,
    parameter logic [AW-1:0] ADDR_OFS = AW'(12'h064),
    parameter logic [AW-1:0] CFG_OFS  = AW'(12'h068),
    parameter logic [AW-1:0] IO_OFS   = AW'(12'h06C),
    localparam int IW = AW - OFS_W
) (
    input  logic [IW-1:0] word_idx,
    output win_tgt_e      tgt
);

    localparam logic [IW-1:0] ADDR_IDX = ADDR_OFS[AW-1:OFS_W];
    localparam logic [IW-1:0] CFG_IDX  = CFG_OFS[AW-1:OFS_W];
    localparam logic [IW-1:0] IO_IDX   = IO_OFS[AW-1:OFS_W];

    always_comb begin
        if (word_idx == ADDR_IDX)     tgt = TGT_ADDR;
        else if (word_idx == CFG_IDX) tgt = TGT_CFG;
        else if (word_idx == IO_IDX)  tgt = TGT_IO;
        else                          tgt = TGT_NONE;
    end

endmodule

// File: rtl/cfgio_target_reg.sv
// Target address latch.
module cfgio_target_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
    end

endmodule

// File: rtl/cfgio_seq.sv
// Sequencer: accepts one host access, runs at most one downstream cycle,
// then acknowledges the host.
module cfgio_seq
    import cfgio_window_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  win_tgt_e         tgt,
    input  logic [LANES-1:0] lane_en,
    input  logic [DW-1:0]    bit_mask,
    input  logic [DW-1:0]    host_wdata,
    input  logic [DW-1:0]    latch_val,
    input  logic             dn_ack,
    input  logic [DW-1:0]    dn_rdata,
    output logic             host_ack,
    output logic [DW-1:0]    host_rdata,
    output logic             latch_load,
    output logic             dn_req,
    output logic             dn_kind,
    output logic             dn_we,
    output logic [DW-1:0]    dn_addr,
    output logic [LANES-1:0] dn_be,
    output logic [DW-1:0]    dn_wdata
);

    fsm_state_e       state_q, state_d;
    cyc_kind_e        kind_q;
    logic             we_q;
    logic [DW-1:0]    addr_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    mask_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic             accept;
    logic             to_window;

    assign accept    = (state_q == ST_IDLE) && host_req;
    assign to_window = (tgt == TGT_CFG) || (tgt == TGT_IO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) state_d = to_window ? ST_DOWN : ST_DONE;
            end
            ST_DOWN: begin
                if (dn_ack) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ack   = (state_q == ST_DONE);
        dn_req     = (state_q == ST_DOWN);
        host_rdata = host_ack ? rdata_q : '0;
        latch_load = accept && host_we && (tgt == TGT_ADDR);
        dn_kind    = kind_q;
        dn_we      = we_q;
        dn_addr    = addr_q;
        dn_be      = be_q;
        dn_wdata   = wdata_q;
    end

    // captured command and returned data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_CFG;
            we_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            kind_q  <= (tgt == TGT_IO) ? KIND_IO : KIND_CFG;
            we_q    <= host_we;
            be_q    <= lane_en;
            mask_q  <= bit_mask;
            wdata_q <= host_wdata & bit_mask;
            addr_q  <= (tgt == TGT_IO) ? latch_val : {latch_val[DW-1:2], 2'b00};
            rdata_q <= (tgt == TGT_ADDR && !host_we) ? latch_val : '0;
        end else if (state_q == ST_DOWN && dn_ack) begin
            rdata_q <= we_q ? '0 : (dn_rdata & mask_q);
        end
    end

endmodule

// File: rtl/cfgio_window.sv
// Indirect configuration / port access window, top level.
module cfgio_window
    import cfgio_window_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32,
    parameter logic [AW-1:0] ADDR_OFS = AW'(12'h064),
    parameter logic [AW-1:0] CFG_OFS  = AW'(12'h068),
    parameter logic [AW-1:0] IO_OFS   = AW'(12'h06C)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [1:0]      host_size,
    input  logic [DW-1:0]   host_wdata,
    output logic            host_ack,
    output logic [DW-1:0]   host_rdata,
    output logic            dn_req,
    output logic            dn_kind,
    output logic            dn_we,
    output logic [DW-1:0]   dn_addr,
    output logic [DW/8-1:0] dn_be,
    output logic [DW-1:0]   dn_wdata,
    input  logic            dn_ack,
    input  logic [DW-1:0]   dn_rdata
);

    localparam int LANES = DW / 8;
    localparam int OFS_W = $clog2(LANES);

    win_tgt_e         tgt;
    logic [LANES-1:0] lane_en;
    logic [DW-1:0]    bit_mask;
    logic [DW-1:0]    latch_val;
    logic             latch_load;

    cfgio_decode #(
        .AW(AW), .OFS_W(OFS_W),
        .ADDR_OFS(ADDR_OFS), .CFG_OFS(CFG_OFS), .IO_OFS(IO_OFS)
    ) u_decode (
        .word_idx (host_addr[AW-1:OFS_W]),
        .tgt      (tgt)
    );

    cfgio_lane_gen #(.DW(DW)) u_lanes (
        .offset   (host_addr[OFS_W-1:0]),
        .size     (host_size),
        .lane_en  (lane_en),
        .bit_mask (bit_mask)
    );

    cfgio_target_reg #(.DW(DW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (latch_load),
        .load_val (host_wdata),
        .value    (latch_val)
    );

    cfgio_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .tgt        (tgt),
        .lane_en    (lane_en),
        .bit_mask   (bit_mask),
        .host_wdata (host_wdata),
        .latch_val  (latch_val),
        .dn_ack     (dn_ack),
        .dn_rdata   (dn_rdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .latch_load (latch_load),
        .dn_req     (dn_req),
        .dn_kind    (dn_kind),
        .dn_we      (dn_we),
        .dn_addr    (dn_addr),
        .dn_be      (dn_be),
        .dn_wdata   (dn_wdata)
    );

endmodule

// File: rtl/cfgio_window_chk.sv
// Protocol checker bound to the window top.
module cfgio_window_chk #(
    parameter int AW = 12,
    parameter int DW = 32,
    parameter logic [AW-1:0] ADDR_OFS = AW'(12'h064),
    localparam int LANES = DW / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_req,
    input logic             host_we,
    input logic [AW-OFS_W-1:0] host_word,
    input logic             host_ack,
    input logic             dn_req,
    input logic             dn_kind,
    input logic             dn_we,
    input logic [DW-1:0]    dn_addr,
    input logic [LANES-1:0] dn_be,
    input logic [DW-1:0]    dn_wdata,
    input logic             dn_ack
);

    localparam logic [AW-OFS_W-1:0] ADDR_IDX = ADDR_OFS[AW-1:OFS_W];

    function automatic logic [DW-1:0] widen(input logic [LANES-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    // R9: request held until answered
    assert_dn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req);

    // R9: command fields steady while waiting
    assert_dn_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> $stable({dn_kind, dn_we, dn_addr, dn_be, dn_wdata}));

    // R9: acknowledge is a single-cycle pulse
    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R10: idle gap after every downstream completion
    assert_dn_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ack |=> !dn_req);

    // R4: configuration addresses are dword aligned
    assert_cfg_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_kind |-> dn_addr[1:0] == 2'b00);

    // R6: byte enables have a legal lane count
    assert_be_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> ($countones(dn_be) == 1 || $countones(dn_be) == 2
                    || $countones(dn_be) == LANES));

    // R7: disabled lanes carry zero write data
    assert_wdata_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_we |-> (dn_wdata & ~widen(dn_be)) == '0);

    // R1: a latch write never starts a downstream cycle
    assert_latch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_we && host_word == ADDR_IDX && !dn_req |=> !dn_req);

endmodule

bind cfgio_window cfgio_window_chk #(.AW(AW), .DW(DW), .ADDR_OFS(ADDR_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_we   (host_we),
    .host_word (host_addr[AW-1:$clog2(DW/8)]),
    .host_ack  (host_ack),
    .dn_req    (dn_req),
    .dn_kind   (dn_kind),
    .dn_we     (dn_we),
    .dn_addr   (dn_addr),
    .dn_be     (dn_be),
    .dn_wdata  (dn_wdata),
    .dn_ack    (dn_ack)
);

// File: tb/cfgio_window_tb.sv
`timescale 1ns/1ps
module cfgio_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        dn_req;
    logic        dn_kind;
    logic        dn_we;
    logic [31:0] dn_addr;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [31:0] dn_rdata = '0;

    always #4 clk = ~clk;

    cfgio_window u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .dn_req(dn_req), .dn_kind(dn_kind), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // responder bookkeeping
    int          dn_count = 0;
    int          gap_bad = 0;
    bit          busy = 1'b0;
    int          wait_cnt = 0;
    logic        seen_kind, seen_we;
    logic [31:0] seen_addr, seen_wdata;
    logic [3:0]  seen_be;

    logic [31:0] model_latch = '0;

    function automatic logic [31:0] resp_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1357};
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001 << off;
            2'd1:    return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // downstream responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (dn_ack) begin
                if (dn_req) gap_bad++;
                dn_ack = 1'b0;
            end else if (dn_req && rst_n) begin
                if (!busy) begin
                    busy = 1'b1;
                    wait_cnt = $urandom_range(0, 3);
                    seen_kind = dn_kind; seen_we = dn_we; seen_addr = dn_addr;
                    seen_be = dn_be; seen_wdata = dn_wdata;
                    dn_count++;
                end
                if (wait_cnt == 0) begin
                    dn_ack = 1'b1;
                    dn_rdata = resp_word(dn_addr);
                    busy = 1'b0;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int guard = 0;
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        do begin
            @(negedge clk);
            guard++;
        end while (!host_ack && guard < 100);
        if (!host_ack) check("R9 no acknowledge", 32'd0, 32'd1);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    // kind: 0 latch write, 1 latch read, 2 cfg window, 3 port window, 4 other offset
    task automatic run_op(input int kind, input bit we, input logic [1:0] off,
                          input logic [1:0] sz, input logic [31:0] wd, input logic [11:0] other);
        logic [11:0] a;
        logic [31:0] rd, exp_addr, m;
        logic [3:0]  be;
        int c0;
        case (kind)
            0, 1:    a = 12'h064 + {10'd0, off};
            2:       a = 12'h068 + {10'd0, off};
            3:       a = 12'h06C + {10'd0, off};
            default: a = other;
        endcase
        c0 = dn_count;
        access((kind == 0) ? 1'b1 : (kind == 1) ? 1'b0 : we, a, sz, wd, rd);
        be = exp_be(off, sz);
        m  = exp_mask(be);
        case (kind)
            0: begin
                model_latch = wd;
                check("R1 latch write made no cycle", dn_count - c0, 0);
            end
            1: begin
                check("R1 latch readback", rd, model_latch);
                check("R1 latch read made no cycle", dn_count - c0, 0);
            end
            2, 3: begin
                check("R9 one downstream cycle", dn_count - c0, 1);
                check(kind == 2 ? "R2 cycle type cfg" : "R3 cycle type port",
                      {31'd0, seen_kind}, (kind == 2) ? 32'd0 : 32'd1);
                check(kind == 2 ? "R2 direction" : "R3 direction", {31'd0, seen_we}, {31'd0, we});
                exp_addr = (kind == 2) ? {model_latch[31:2], 2'b00} : model_latch;
                check(kind == 2 ? "R4 cfg address" : "R5 port address", seen_addr, exp_addr);
                check("R6 byte enables", {28'd0, seen_be}, {28'd0, be});
                if (we) check("R7 write lanes", seen_wdata, wd & m);
                else    check("R8 read lanes", rd, resp_word(exp_addr) & m);
            end
            default: begin
                check("R11 other offset made no cycle", dn_count - c0, 0);
                check("R11 other offset reads zero", rd, 32'd0);
            end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 dn_req after reset", {31'd0, dn_req}, 32'd0);
        check("R12 host_ack after reset", {31'd0, host_ack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1, 0, 2'd0, 2'd2, 32'd0, 12'h0);              // R12 latch reads zero

        // R1/R10: latch write followed at once by a cfg read, then type change
        run_op(0, 1, 2'd0, 2'd2, 32'h0012_3A4E, 12'h0);
        run_op(2, 0, 2'd0, 2'd2, 32'd0, 12'h0);
        run_op(3, 0, 2'd0, 2'd2, 32'd0, 12'h0);
        run_op(0, 1, 2'd0, 2'd2, 32'h0000_03F9, 12'h0);
        run_op(3, 1, 2'd1, 2'd0, 32'hDEAD_BEEF, 12'h0);
        run_op(2, 1, 2'd3, 2'd1, 32'hCAFE_F00D, 12'h0);

        // R6: every byte lane, both halves, reserved size
        for (int o = 0; o < 4; o++) begin
            run_op(2, 0, 2'(o), 2'd0, 32'd0, 12'h0);
            run_op(3, 1, 2'(o), 2'd1, 32'hA1B2_C3D4, 12'h0);
        end
        run_op(2, 1, 2'd2, 2'd3, 32'h1357_9BDF, 12'h0);

        // R11: write to other offsets leaves latch untouched
        run_op(4, 1, 2'd0, 2'd2, 32'hFFFF_FFFF, 12'h060);
        run_op(4, 1, 2'd0, 2'd2, 32'h5555_AAAA, 12'h070);
        run_op(1, 0, 2'd0, 2'd2, 32'd0, 12'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            int kind = (k < 2) ? 0 : (k < 3) ? 1 : (k < 6) ? 2 : (k < 9) ? 3 : 4;
            logic [11:0] oth = ($urandom_range(0, 1) == 0) ? 12'h070 : 12'h7B4;
            run_op(kind, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                   2'($urandom_range(0, 3)), $urandom(), oth);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        check("R10 idle gap after completion", gap_bad, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule